// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words and returns a 32-bit product together with overflow and underflow indications. Each operand word carries its sign in bit 31, an 8-bit exponent stored with an offset of 127 in bits 30:23, and a 23-bit fraction in bits 22:0. The value is (-1)^sign × 1.fraction × 2^(exponent-127). The block unpacks both words and restores the implicit leading one of each significand. It then multiplies the two 24-bit significands without sign, adds the two stored exponents and removes one offset, and takes the result sign as the XOR of the operand signs.

The 48-bit significand product lies in [1,4). When it is 2 or more, the block shifts it right by one and raises the exponent by one. The 23 fraction bits that follow the leading one are kept and the rest are dropped (truncation). Results above the exponent range saturate to infinity of the result sign. Results below it flush to zero of the result sign. An operand whose exponent field is 0 counts as zero; there is no subnormal support and no NaN handling.

The datapath has two register stages. A strobe that accompanies the operands comes out as an output strobe two clock cycles later, aligned with the product and flags. A new operand pair may be presented on every cycle.

Top module: `fp32_mul_unit`

## Requirements
- R1: For every valid result, product bit 31 equals op_a bit 31 XOR op_b bit 31, including zero, infinity and flushed results.
- R2: For two nonzero operands with exponent fields 1..254 and a significand product below 2, the result exponent field is ea+eb-127 and the result fraction is bits 45:23 of the 48-bit product of {1,fa} and {1,fb}. The lower bits are truncated.
- R3: When the significand product is 2 or more (bit 47 set), the result fraction is bits 46:24 and the result exponent field is ea+eb-126.
- R4: If either operand has exponent field 0, the product is {sign,31'b0} and both flags are low. This takes priority over every other case, including an exponent field of 255 on the other operand.
- R5: If the normalized result exponent is 255 or more, or either (nonzero) operand has exponent field 255, the product is {sign,8'hFF,23'b0} and ovf_flag is high.
- R6: If the normalized result exponent is 0 or less, the product is {sign,31'b0} and unf_flag is high.
- R7: out_valid is high exactly two clock cycles after in_valid was high, and ovf_flag and unf_flag are never high together.
- R8: While rst_n is low (synchronous, active low), out_valid, product, ovf_flag and unf_flag are all 0 after the next clock edge, whatever the inputs.
- R9: ovf_flag and unf_flag are low on every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result present this cycle |
| product | output | 32 | Packed result word |
| ovf_flag | output | 1 | Result saturated to infinity |
| unf_flag | output | 1 | Result flushed to zero |

## Verification
Some rules hold on every cycle, and the assertions check them there. These are the two-cycle strobe alignment, the sign rule, the exclusive flags, the flag-idle rule, the reset clearing, the exact bit patterns of saturated and flushed words, and the ban on an exponent field of 255 in a normal result. The arithmetic cannot be checked that way. Which fraction bits are kept, whether the normalization shift happens, the exact exponent thresholds at 0 and 255, and the priority of zero operands over code 255 all depend on the operand values. Only the bench's scenarios show these: directed boundary pairs plus a long run of pseudo-random pairs, compared with a behavioural integer model.

// File: rtl/fp32_mul_pkg.sv
`timescale 1ns/1ps
// Package: fp32_mul_pkg
// Purpose : default field widths for the single-precision multiplier.
// Assumes : binary interchange layout, sign at the top.
package fp32_mul_pkg;
    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;
    localparam int FP_WORD_W = 1 + FP_EXP_W + FP_FRAC_W;
endpackage

// File: rtl/fp_field_split.sv
`timescale 1ns/1ps
// Module : fp_field_split
// Purpose: splits one packed word into sign, exponent and significand,
//          restoring the hidden one, and classifies the exponent code.
// Assumes: an exponent code of zero denotes zero (no subnormals).
module fp_field_split #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  expo,
    output logic [SIG_W-1:0]  sig,
    output logic              is_zero,
    output logic              is_top
);
    // Field extraction and code classification.
    always_comb begin
        sign    = word[WORD_W-1];
        expo    = word[WORD_W-2 -: EXP_W];
        sig     = {1'b1, word[FRAC_W-1:0]};
        is_zero = (expo == '0);
        is_top  = (expo == '1);
    end
endmodule

// File: rtl/sig_array_mult.sv
`timescale 1ns/1ps
// Module : sig_array_mult
// Purpose: unsigned significand multiplier built as a row chain of
//          shifted partial products.
// Assumes: operands are plain unsigned magnitudes.
module sig_array_mult #(
    parameter int SIG_W = 24,
    localparam int PW   = 2 * SIG_W
) (
    input  logic [SIG_W-1:0] ma,
    input  logic [SIG_W-1:0] mb,
    output logic [PW-1:0]    prod
);
    logic [PW-1:0] part [SIG_W+1];

    assign part[0] = '0;

    // One row per multiplier bit: add the shifted multiplicand when set.
    for (genvar gi = 0; gi < SIG_W; gi++) begin : g_row
        assign part[gi+1] = part[gi] + (mb[gi] ? (PW'(ma) << gi) : '0);
    end

    assign prod = part[SIG_W];
endmodule

// File: rtl/fp_norm_pack.sv
`timescale 1ns/1ps
// Module : fp_norm_pack
// Purpose: normalizes the significand product by at most one place,
//          applies range limits and packs the result word and flags.
// Assumes: exp_in already holds ea+eb-bias as a signed value; the
//          product lies in [1,4) so one right shift suffices.
module fp_norm_pack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int PW     = 2 * (FRAC_W + 1),
    localparam int ESW    = EXP_W + 2
) (
    input  logic                  valid,
    input  logic                  sign,
    input  logic                  any_zero,
    input  logic                  any_top,
    input  logic signed [ESW-1:0] exp_in,
    input  logic [PW-1:0]         prod,
    output logic [WORD_W-1:0]     word,
    output logic                  ovf,
    output logic                  unf
);
    localparam logic signed [ESW-1:0] E_CEIL = ESW'((1 << EXP_W) - 1);

    logic                  shift;
    logic [FRAC_W-1:0]     frac;
    logic signed [ESW-1:0] exp_adj;

    // Normalization: bit PW-1 decides between the two fraction windows.
    always_comb begin
        shift   = prod[PW-1];
        frac    = shift ? prod[PW-2 -: FRAC_W] : prod[PW-3 -: FRAC_W];
        exp_adj = exp_in + (shift ? ESW'(1) : ESW'(0));
    end

    // Packing with priority zero > saturate > flush > normal.
    always_comb begin
        ovf = 1'b0;
        unf = 1'b0;
        if (any_zero) begin
            word = {sign, {(WORD_W-1){1'b0}}};
        end else if (any_top || exp_adj >= E_CEIL) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf  = valid;
        end else if (exp_adj <= 0) begin
            word = {sign, {(WORD_W-1){1'b0}}};
            unf  = valid;
        end else begin
            word = {sign, exp_adj[EXP_W-1:0], frac};
        end
    end
endmodule

// File: rtl/fp32_mul_unit.sv
`timescale 1ns/1ps
// Module : fp32_mul_unit
// Purpose: two-stage floating-point multiplier. Stage 1 unpacks, adds
//          exponents and multiplies significands; stage 2 normalizes,
//          packs and registers the result with its flags.
// Assumes: truncation only, no subnormal or NaN handling.
module fp32_mul_unit
    import fp32_mul_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PW     = 2 * SIG_W,
    localparam int ESW    = EXP_W + 2,
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] product,
    output logic              ovf_flag,
    output logic              unf_flag
);
    logic [WORD_W-1:0] ops   [2];
    logic              sgn   [2];
    logic [EXP_W-1:0]  expo  [2];
    logic [SIG_W-1:0]  sig   [2];
    logic              zro   [2];
    logic              top   [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One field splitter per operand.
    for (genvar gi = 0; gi < 2; gi++) begin : g_split
        fp_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) split_i (
            .word    (ops[gi]),
            .sign    (sgn[gi]),
            .expo    (expo[gi]),
            .sig     (sig[gi]),
            .is_zero (zro[gi]),
            .is_top  (top[gi])
        );
    end

    logic [PW-1:0]         prod_w;
    logic signed [ESW-1:0] exp_sum;

    sig_array_mult #(.SIG_W(SIG_W)) mult_i (
        .ma   (sig[0]),
        .mb   (sig[1]),
        .prod (prod_w)
    );

    // Exponent adder: both codes carry the offset, so remove one copy.
    always_comb begin
        exp_sum = $signed({2'b00, expo[0]}) + $signed({2'b00, expo[1]})
                - ESW'(BIAS);
    end

    logic                  s1_valid;
    logic                  s1_sign;
    logic                  s1_zero;
    logic                  s1_top;
    logic signed [ESW-1:0] s1_exp;
    logic [PW-1:0]         s1_prod;

    // Stage 1 register: unpacked and multiplied operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_zero  <= 1'b0;
            s1_top   <= 1'b0;
            s1_exp   <= '0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sign  <= sgn[0] ^ sgn[1];
            s1_zero  <= zro[0] | zro[1];
            s1_top   <= top[0] | top[1];
            s1_exp   <= exp_sum;
            s1_prod  <= prod_w;
        end
    end

    logic [WORD_W-1:0] pk_word;
    logic              pk_ovf;
    logic              pk_unf;

    fp_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) pack_i (
        .valid    (s1_valid),
        .sign     (s1_sign),
        .any_zero (s1_zero),
        .any_top  (s1_top),
        .exp_in   (s1_exp),
        .prod     (s1_prod),
        .word     (pk_word),
        .ovf      (pk_ovf),
        .unf      (pk_unf)
    );

    // Stage 2 register: packed result and flags at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
            ovf_flag  <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            product   <= pk_word;
            ovf_flag  <= pk_ovf;
            unf_flag  <= pk_unf;
        end
    end
endmodule

// File: rtl/fp32_mul_chk.sv
`timescale 1ns/1ps
// Module : fp32_mul_chk
// Purpose: cycle-level properties of fp32_mul_unit, bound to the top.
// Assumes: 32-bit words with 8 exponent bits.
module fp32_mul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        out_valid,
    input logic [31:0] product,
    input logic        ovf_flag,
    input logic        unf_flag
);
    logic [1:0] vld_d;
    logic [1:0] sgn_d;

    // Observation pipe of strobe and expected sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_d <= '0;
            sgn_d <= '0;
        end else begin
            vld_d <= {vld_d[0], in_valid};
            sgn_d <= {sgn_d[0], op_a[31] ^ op_b[31]};
        end
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == 32'h0 && !ovf_flag && !unf_flag));

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_d[1]);

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

    // R9
    flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!ovf_flag && !unf_flag));

    // R1
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product[31] == sgn_d[1]);

    // R5
    sat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> product[30:0] == 31'h7F80_0000);

    // R6
    flush_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> product[30:0] == 31'h0);

    // R2
    exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ovf_flag) |-> product[30:23] != 8'hFF);
endmodule

bind fp32_mul_unit fp32_mul_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/fp32_mul_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: drives operand pairs on falling edges, keeps a queue of
// expected results from a behavioural integer model, and compares the
// outputs two falling edges later.
module fp32_mul_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] product;
    logic        ovf_flag;
    logic        unf_flag;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit        v;
        bit [31:0] w;
        bit        o;
        bit        u;
        string     tag;
    } exp_t;

    exp_t exp_q [$];

    always #2.5 clk = ~clk;

    fp32_mul_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .product   (product),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Behavioural model of the multiplication rules.
    function automatic void ref_mul(input bit [31:0] a, input bit [31:0] b,
                                    output bit [31:0] w, output bit o,
                                    output bit u, output string tag);
        int     ea = int'(a[30:23]);
        int     eb = int'(b[30:23]);
        bit     s  = a[31] ^ b[31];
        longint ma = longint'({1'b1, a[22:0]});
        longint mb = longint'({1'b1, b[22:0]});
        longint p;
        int     e;
        int     fr;
        o = 1'b0;
        u = 1'b0;
        if (ea == 0 || eb == 0) begin
            w = {s, 31'h0}; tag = "R4";
        end else if (ea == 255 || eb == 255) begin
            w = {s, 8'hFF, 23'h0}; o = 1'b1; tag = "R5";
        end else begin
            p = ma * mb;
            e = ea + eb - 127;
            if (p >= (longint'(1) << 47)) begin
                fr = int'((p >> 24) & 64'h7F_FFFF); e = e + 1; tag = "R3";
            end else begin
                fr = int'((p >> 23) & 64'h7F_FFFF); tag = "R2";
            end
            if (e >= 255) begin
                w = {s, 8'hFF, 23'h0}; o = 1'b1; tag = "R5";
            end else if (e <= 0) begin
                w = {s, 31'h0}; u = 1'b1; tag = "R6";
            end else begin
                w = {s, e[7:0], fr[22:0]};
            end
        end
    endfunction

    // One cycle: compare the result due now, then drive the next pair.
    task automatic step(input bit v, input bit [31:0] a, input bit [31:0] b);
        exp_t e;
        exp_t n;
        @(negedge clk);
        if (exp_q.size() >= 2) begin
            e = exp_q.pop_front();
            checks++;
            if (out_valid !== e.v) begin
                errors++;
                $display("FAIL R7: out_valid=%b expected %b", out_valid, e.v);
            end
            if (e.v) begin
                checks++;
                if (product !== e.w || ovf_flag !== e.o || unf_flag !== e.u) begin
                    errors++;
                    $display("FAIL %s: product=%h ovf=%b unf=%b expected %h %b %b",
                             e.tag, product, ovf_flag, unf_flag, e.w, e.o, e.u);
                end
                checks++;
                if (product[31] !== e.w[31]) begin
                    errors++;
                    $display("FAIL R1: sign=%b expected %b", product[31], e.w[31]);
                end
            end else begin
                checks++;
                if (ovf_flag !== 1'b0 || unf_flag !== 1'b0) begin
                    errors++;
                    $display("FAIL R9: ovf=%b unf=%b expected 0 0", ovf_flag, unf_flag);
                end
            end
        end
        in_valid = v;
        op_a     = a;
        op_b     = b;
        n.v = v;
        ref_mul(a, b, n.w, n.o, n.u, n.tag);
        exp_q.push_back(n);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end

    initial begin
        bit [31:0] seed = 32'h1357_9BDF;
        bit [31:0] ra;
        bit [31:0] rb;

        // R8: reset dominates active inputs.
        in_valid = 1'b1;
        op_a = 32'h3FC0_0000;
        op_b = 32'h7F00_0000;
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || product !== 32'h0 || ovf_flag !== 1'b0 || unf_flag !== 1'b0) begin
                errors++;
                $display("FAIL R8: v=%b p=%h o=%b u=%b expected all 0",
                         out_valid, product, ovf_flag, unf_flag);
            end
        end
        rst_n = 1'b1;
        in_valid = 1'b0;

        // R2: 1.0 x 1.0 and -18 x 9.5 = -171.
        step(1, 32'h3F80_0000, 32'h3F80_0000);
        step(1, 32'hC190_0000, 32'h4118_0000);
        // R3: 1.5 x 1.5 = 2.25 needs the shift.
        step(1, 32'h3FC0_0000, 32'h3FC0_0000);
        step(0, 32'h0, 32'h0);
        // R2: truncation of a long fraction (13.45 x 3.0).
        step(1, 32'h4157_3333, 32'h4040_0000);
        // R4: zero operands, signed, and zero beats code 255.
        step(1, 32'h0000_0000, 32'h40A0_0000);
        step(1, 32'h8000_0000, 32'h4000_0000);
        step(1, 32'h7F80_0000, 32'h0000_0000);
        step(1, 32'h0012_3456, 32'hC000_0000);
        // R5: saturation and its boundary.
        step(1, 32'h7F00_0000, 32'h7F00_0000);
        step(1, 32'h7F00_0000, 32'hC000_0000);
        step(1, 32'h7E80_0000, 32'h4000_0000);
        step(1, 32'h7F80_0000, 32'h4000_0000);
        step(1, 32'h7F7F_FFFF, 32'h3FFF_FFFF);
        // R6: flush and its boundary.
        step(1, 32'h0080_0000, 32'h0080_0000);
        step(1, 32'h0080_0000, 32'h3F80_0000);
        step(1, 32'h8080_0000, 32'h3F00_0000);
        step(1, 32'h00C0_0000, 32'h3FAA_AAAB);
        // R7: back-to-back and gaps.
        step(0, 32'h3F80_0000, 32'h3F80_0000);
        step(1, 32'hBF80_0000, 32'hBF80_0000);
        step(0, 32'h0, 32'h0);
        step(0, 32'h0, 32'h0);

        // Pseudo-random pairs: mostly mid-range, some full-range.
        for (int i = 0; i < 600; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            ra = seed;
            seed = seed * 32'd1664525 + 32'd1013904223;
            rb = seed;
            if (i % 3 != 0) begin
                ra[30:23] = 8'd64 + {1'b0, ra[30:24]};
                rb[30:23] = 8'd64 + {1'b0, rb[30:24]};
            end
            step((i % 7) != 3, ra, rb);
        end

        step(0, 32'h0, 32'h0);
        step(0, 32'h0, 32'h0);
        step(0, 32'h0, 32'h0);
        summary();
        $finish;
    end
endmodule